// File: doc/BRIEF.md
# Floating-Point Operand Unpacker and Classifier

This block takes one packed operand and turns it into a single unpacked form that the arithmetic units behind it can use for any format. It accepts a 32-bit signed integer, an IEEE single, an IEEE double or a 128-bit quad, all on one 128-bit operand bus. The operand is left-justified: the most significant word sits in bits 127:96, and narrower formats leave the lower words unused. The result is registered one clock after a valid strobe.

The output is a sign bit, a signed unbiased exponent, a 113-bit mantissa and a class code. For every numeric result the mantissa's leading one is at bit 112, and fractions from the narrower formats are left-aligned beneath that bit. Denormals and integers are brought to this form by a leading-zero count and a left shift. Signalling NaNs are made quiet on the way in and raise the invalid-operation flag. All four formats share one classification rule, based on an all-zero or all-ones exponent field and a zero or non-zero fraction.

Top module: `fp_unpack`

## Requirements
- R1: The outputs are registered. One clock after a cycle with `in_valid` high, `out_valid` is high and the other outputs describe that operand. After a cycle with `in_valid` low, `out_valid` is low and all other outputs keep their previous values.
- R2: While `rst_n` is low at a clock edge, every output is driven to zero. Reset is synchronous.
- R3: `out_sign` is always bit 127 of the operand bus, for every format including integers.
- R4: Type codes are 0 = integer, 1 = single, 2 = double and 3 = quad. Class codes are 0 = ZERO, 1 = NUMBER, 2 = INFINITY, 3 = QUIET NaN and 4 = SIGNALLING NaN. The exponent field starts at bit 126 and is 8, 11 or 15 bits wide, with bias 127, 1023 or 16383. The fraction follows directly below it and is 23, 52 or 112 bits wide. The integer is bits 127:96.
- R5: A zero exponent field with a zero fraction gives class ZERO, with a zero mantissa and a zero exponent.
- R6: For a normal number (exponent field neither all-zeros nor all-ones), the exponent is the field minus the bias. The mantissa is a one at bit 112 with the fraction left-aligned from bit 111 down.
- R7: For a denormal (zero exponent field, non-zero fraction), no implicit one is added. The aligned fraction is shifted left until its top set bit reaches bit 112, and the exponent is (1 − bias) minus the shift count.
- R8: An all-ones exponent field with a zero fraction gives class INFINITY, with a zero mantissa and a zero exponent.
- R9: An all-ones exponent field with a non-zero fraction whose top bit is set gives class QUIET NaN. The mantissa is the aligned fraction with bit 112 clear, and the exponent is zero.
- R10: An all-ones exponent field with a non-zero fraction whose top bit is clear gives class SIGNALLING NaN. The mantissa is the aligned fraction with bit 111 set, and the exponent is zero.
- R11: An integer of zero gives class ZERO. Any other integer gives class NUMBER, with the magnitude of its two's-complement value normalized to bit 112 and an exponent of 31 minus the shift count. This holds for −2^31 as well.
- R12: `out_invalid` is high exactly when the class is SIGNALLING NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_type | input | 2 | Format of the operand |
| in_opnd | input | 128 | Left-justified packed operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_sign | output | 1 | Sign of the operand |
| out_exp | output | 17 | Signed unbiased exponent |
| out_mant | output | 113 | Unpacked mantissa, leading one at bit 112 |
| out_class | output | 3 | Class code |
| out_invalid | output | 1 | Invalid-operation flag |

## Verification
The assertions assume that `in_type` is always one of the four legal codes and that `in_valid` and `in_opnd` hold a known value at every clock edge. Under those assumptions a mantissa with bit 112 set, zero payloads and a quiet bit on NaNs all follow from the block itself. The stimulus drives only defined values, on the falling edge. It mixes directed corner operands (the most negative integer, the smallest denormal of each format, both NaN kinds, the infinities and signed zeros) with random operands of every type and some idle cycles. The expected results come from the bench's own behavioural model.

// File: rtl/fp_unpack_pkg.sv
// Package: shared widths, codes and the unpacked result type.
// Assumes a 128-bit left-justified operand and a 113-bit internal mantissa.
package fp_unpack_pkg;
    localparam int OPND_W  = 128;
    localparam int MANT_W  = 113;
    localparam int EXP_W   = 17;
    localparam int INT_W   = 32;
    localparam int LZC_W   = $clog2(MANT_W + 1);

    typedef enum logic [1:0] {
        FMT_INT  = 2'd0,
        FMT_SNG  = 2'd1,
        FMT_DBL  = 2'd2,
        FMT_QUAD = 2'd3
    } fmt_e;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_NUM  = 3'd1,
        CLS_INF  = 3'd2,
        CLS_QNAN = 3'd3,
        CLS_SNAN = 3'd4
    } cls_e;

    typedef struct packed {
        logic signed [EXP_W-1:0] exp;
        logic [MANT_W-1:0]       mant;
        cls_e                    cls;
        logic                    invalid;
    } unpk_t;

    // Exponent field width of each float format
    function automatic int exp_bits(input int fmt);
        return (fmt == 1) ? 8 : (fmt == 2) ? 11 : 15;
    endfunction

    // Fraction field width of each float format
    function automatic int frac_bits(input int fmt);
        return (fmt == 1) ? 23 : (fmt == 2) ? 52 : 112;
    endfunction
endpackage

// File: rtl/fp_lzc.sv
// Leading-zero counter.
// Returns the number of zeros above the highest set bit, or W when the vector is zero.
module fp_lzc #(
    parameter int W  = 113,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // Scan upward so that the highest set bit sets the count last
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fp_normalize.sv
// Normalizer: moves the leading one to the top bit and lowers the exponent by the shift.
// Assumes the caller enables it only for non-zero numeric mantissas.
module fp_normalize #(
    parameter int MW = 113,
    parameter int EW = 17
) (
    input  logic                 en,
    input  logic [MW-1:0]        mant_i,
    input  logic signed [EW-1:0] exp_i,
    output logic [MW-1:0]        mant_o,
    output logic signed [EW-1:0] exp_o
);
    localparam int CW = $clog2(MW + 1);

    logic [CW-1:0] lz;

    fp_lzc #(.W(MW), .CW(CW)) i_lzc (
        .vec (mant_i),
        .cnt (lz)
    );

    // Shift and exponent adjust, bypassed when not enabled
    always_comb begin
        if (en) begin
            mant_o = mant_i << lz;
            exp_o  = exp_i - $signed({{(EW-CW){1'b0}}, lz});
        end else begin
            mant_o = mant_i;
            exp_o  = exp_i;
        end
    end
endmodule

// File: rtl/fp_float_decode.sv
// Float field decoder for one format: classifies the operand and builds
// the pre-normalization exponent and aligned mantissa. NaNs are quieted here.
// Assumes the exponent field starts at bit 126 with the fraction right below it.
module fp_float_decode
    import fp_unpack_pkg::*;
#(
    parameter int EB = 8,
    parameter int FB = 23
) (
    input  logic [OPND_W-1:0] opnd,
    output unpk_t             res,
    output logic              denorm
);
    localparam int               FR_W  = MANT_W - 1;
    localparam int               BIAS  = (1 << (EB - 1)) - 1;
    localparam logic [EB-1:0]    E_MAX = '1;

    logic [EB-1:0]   fld;
    logic [FB-1:0]   frac;
    logic [FR_W-1:0] frac_al;
    logic            frac_nz;

    // Field extraction and left alignment of the fraction
    always_comb begin
        fld     = opnd[OPND_W-2 -: EB];
        frac    = opnd[OPND_W-2-EB -: FB];
        frac_al = FR_W'(frac) << (FR_W - FB);
        frac_nz = |frac;
    end

    // Classification and pre-normalization payload
    always_comb begin
        res     = '0;
        denorm  = 1'b0;
        if (fld == '0) begin
            if (frac_nz) begin
                res.cls  = CLS_NUM;
                res.exp  = EXP_W'(1 - BIAS);
                res.mant = {1'b0, frac_al};
                denorm   = 1'b1;
            end else begin
                res.cls  = CLS_ZERO;
            end
        end else if (fld == E_MAX) begin
            if (!frac_nz) begin
                res.cls = CLS_INF;
            end else if (frac_al[FR_W-1]) begin
                res.cls  = CLS_QNAN;
                res.mant = {1'b0, frac_al};
            end else begin
                res.cls     = CLS_SNAN;
                res.invalid = 1'b1;
                res.mant    = {2'b01, frac_al[FR_W-2:0]};
            end
        end else begin
            res.cls  = CLS_NUM;
            res.exp  = $signed({{(EXP_W-EB){1'b0}}, fld}) - EXP_W'(BIAS);
            res.mant = {1'b1, frac_al};
        end
    end
endmodule

// File: rtl/fp_int_decode.sv
// Integer decoder: turns a 32-bit two's-complement word into a magnitude
// placed at the mantissa top, with exponent 31 before normalization.
module fp_int_decode
    import fp_unpack_pkg::*;
(
    input  logic [INT_W-1:0] word,
    output unpk_t            res
);
    logic [INT_W-1:0] mag;

    // Magnitude; the most negative value maps onto its own bit pattern
    always_comb begin
        mag = word[INT_W-1] ? (~word + 1'b1) : word;
    end

    // Class and pre-normalization payload
    always_comb begin
        res = '0;
        if (word != '0) begin
            res.cls  = CLS_NUM;
            res.exp  = EXP_W'(INT_W - 1);
            res.mant = {mag, {(MANT_W-INT_W){1'b0}}};
        end
    end
endmodule

// File: rtl/fp_unpack.sv
// Operand unpacker top: decodes all four formats in parallel, selects one by type,
// normalizes numbers and registers the result one clock after the strobe.
// Assumes in_type always carries a legal code; outputs hold while no strobe arrives.
module fp_unpack
    import fp_unpack_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              in_type,
    input  logic [127:0]            in_opnd,
    output logic                    out_valid,
    output logic                    out_sign,
    output logic signed [16:0]      out_exp,
    output logic [112:0]            out_mant,
    output logic [2:0]              out_class,
    output logic                    out_invalid
);
    localparam int N_FMT = 4;

    unpk_t             dec [N_FMT];
    logic [N_FMT-1:0]  dec_dn;
    unpk_t             sel;
    logic              norm_en;
    logic [MANT_W-1:0] mant_n;
    logic signed [EXP_W-1:0] exp_n;

    fp_int_decode i_int (
        .word (in_opnd[OPND_W-1 -: INT_W]),
        .res  (dec[0])
    );
    assign dec_dn[0] = 1'b0;

    for (genvar f = 1; f < N_FMT; f++) begin : g_fmt
        fp_float_decode #(
            .EB (exp_bits(f)),
            .FB (frac_bits(f))
        ) i_dec (
            .opnd   (in_opnd),
            .res    (dec[f]),
            .denorm (dec_dn[f])
        );
    end

    // Format select
    always_comb begin
        sel     = dec[in_type];
        norm_en = (sel.cls == CLS_NUM) && ((in_type == FMT_INT) || dec_dn[in_type]);
    end

    fp_normalize #(.MW(MANT_W), .EW(EXP_W)) i_norm (
        .en     (norm_en),
        .mant_i (sel.mant),
        .exp_i  (sel.exp),
        .mant_o (mant_n),
        .exp_o  (exp_n)
    );

    // Output register: strobe follows in_valid, payload loads on strobe only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_sign    <= 1'b0;
            out_exp     <= '0;
            out_mant    <= '0;
            out_class   <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sign    <= in_opnd[OPND_W-1];
                out_exp     <= exp_n;
                out_mant    <= mant_n;
                out_class   <= sel.cls;
                out_invalid <= sel.invalid;
            end
        end
    end
endmodule

// File: rtl/fp_unpack_chk.sv
// Checker for fp_unpack: port-level properties of the registered result.
// Assumes legal type codes and known inputs at every edge.
module fp_unpack_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [127:0] in_opnd,
    input logic         out_valid,
    input logic         out_sign,
    input logic [16:0]  out_exp,
    input logic [112:0] out_mant,
    input logic [2:0]   out_class,
    input logic         out_invalid
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_mant) && $stable(out_exp)); // R1
    AST_SIGN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_sign == $past(in_opnd[127])); // R3
    AST_CLASS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_class <= 3'd4); // R4
    AST_ZERO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_class == 3'd0 |-> out_mant == '0 && out_exp == '0); // R5
    AST_NUM_LEADING_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_class == 3'd1 |-> out_mant[112]); // R6
    AST_INF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_class == 3'd2 |-> out_mant == '0); // R8
    AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_class == 3'd3 || out_class == 3'd4) |-> out_mant[111] && !out_mant[112]); // R10
    AST_INVALID_ONLY_SNAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_invalid == (out_class == 3'd4)); // R12
endmodule

bind fp_unpack fp_unpack_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_opnd     (in_opnd),
    .out_valid   (out_valid),
    .out_sign    (out_sign),
    .out_exp     (out_exp),
    .out_mant    (out_mant),
    .out_class   (out_class),
    .out_invalid (out_invalid)
);

// File: tb/test_fp_unpack.sv
// Bench for fp_unpack: a behavioural model predicts each registered result,
// and every clock the outputs are compared on the falling edge.
module test_fp_unpack;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   in_type = 2'd0;
    logic [127:0] in_opnd = '0;
    logic         out_valid;
    logic         out_sign;
    logic signed [16:0] out_exp;
    logic [112:0] out_mant;
    logic [2:0]   out_class;
    logic         out_invalid;

    int n_cmp = 0;
    int n_bad = 0;

    // Expected output state
    logic         e_valid = 1'b0;
    logic         e_sign = 1'b0;
    int           e_exp = 0;
    logic [112:0] e_mant = '0;
    int           e_cls = 0;
    logic         e_inv = 1'b0;
    string        e_tag = "R2";

    always #4 clk = ~clk;

    fp_unpack i_fp_unpack (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_type (in_type),
        .in_opnd (in_opnd), .out_valid (out_valid), .out_sign (out_sign),
        .out_exp (out_exp), .out_mant (out_mant), .out_class (out_class),
        .out_invalid (out_invalid)
    );

    // Reference model of the unpacked form
    task automatic model(input logic [1:0] t, input logic [127:0] op);
        logic [127:0] sh;
        logic [111:0] fa;
        logic [31:0]  w, mag;
        int ew, fw, fld, bias, emax;
        e_sign = op[127];
        e_inv  = 1'b0;
        e_exp  = 0;
        e_mant = '0;
        if (t == 2'd0) begin
            e_tag = "R11";
            w = op[127:96];
            if (w == 0) begin
                e_cls = 0;
            end else begin
                mag = w[31] ? -w : w;
                e_mant = {mag, 81'd0};
                e_exp = 31;
                while (!e_mant[112]) begin e_mant = e_mant << 1; e_exp--; end
                e_cls = 1;
            end
            return;
        end
        ew = (t == 2'd1) ? 8 : (t == 2'd2) ? 11 : 15;
        fw = (t == 2'd1) ? 23 : (t == 2'd2) ? 52 : 112;
        fld = int'(op[126 -: 15]) >> (15 - ew);
        sh = op << (1 + ew);
        fa = sh[127:16];
        if (fw < 112) fa = fa & ~((112'(1) << (112 - fw)) - 112'(1));
        bias = (1 << (ew - 1)) - 1;
        emax = (1 << ew) - 1;
        if (fld == 0 && fa == 0) begin
            e_cls = 0; e_tag = "R5";
        end else if (fld == 0) begin
            e_cls = 1; e_tag = "R7";
            e_mant = {1'b0, fa};
            e_exp = 1 - bias;
            while (!e_mant[112]) begin e_mant = e_mant << 1; e_exp--; end
        end else if (fld == emax && fa == 0) begin
            e_cls = 2; e_tag = "R8";
        end else if (fld == emax) begin
            e_mant = {1'b0, fa};
            if (e_mant[111]) begin
                e_cls = 3; e_tag = "R9";
            end else begin
                e_mant[111] = 1'b1; e_cls = 4; e_inv = 1'b1; e_tag = "R10";
            end
        end else begin
            e_cls = 1; e_tag = "R6";
            e_mant = {1'b1, fa};
            e_exp = fld - bias;
        end
    endtask

    // One comparison of every output against the expected state
    task automatic compare();
        n_cmp++;
        if (out_valid !== e_valid) begin
            n_bad++; $display("FAIL R1 valid: got %0b exp %0b", out_valid, e_valid);
        end
        if (out_sign !== e_sign) begin
            n_bad++; $display("FAIL R3 (%s) sign: got %0b exp %0b", e_tag, out_sign, e_sign);
        end
        if ($signed(out_exp) != e_exp) begin
            n_bad++; $display("FAIL R4/%s exponent: got %0d exp %0d", e_tag, $signed(out_exp), e_exp);
        end
        if (out_mant !== e_mant) begin
            n_bad++; $display("FAIL R4/%s mantissa: got %h exp %h", e_tag, out_mant, e_mant);
        end
        if (int'(out_class) != e_cls) begin
            n_bad++; $display("FAIL R4/%s class: got %0d exp %0d", e_tag, out_class, e_cls);
        end
        if (out_invalid !== e_inv) begin
            n_bad++; $display("FAIL R12 (%s) invalid: got %0b exp %0b", e_tag, out_invalid, e_inv);
        end
    endtask

    // One clock step: check the previous result, then drive the next input
    task automatic step(input logic v, input logic [1:0] t, input logic [127:0] op);
        @(negedge clk);
        compare();
        in_valid = v; in_type = t; in_opnd = op;
        e_valid = v;
        if (v) model(t, op);
    endtask

    function automatic logic [127:0] top32(input logic [31:0] w);
        return {w, 96'd0};
    endfunction

    function automatic logic [127:0] top64(input logic [63:0] w);
        return {w, 64'd0};
    endfunction

    // Stimulus
    initial begin
        // R2: reset state, with a live strobe held during reset
        in_valid = 1'b1; in_opnd = '1; in_type = 2'd3;
        repeat (3) @(negedge clk);
        compare();
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;
        // R11: integer corners
        step(1, 0, top32(32'h0000_0000));
        step(1, 0, top32(32'h0000_0001));
        step(1, 0, top32(32'hFFFF_FFFF));
        step(1, 0, top32(32'h8000_0000));
        step(1, 0, top32(32'h7FFF_FFFF));
        step(1, 0, {32'd12345, 96'hDEAD_BEEF_0123_4567_89AB_CDEF});
        // Single corners: R5 R6 R7 R8 R9 R10
        step(1, 1, top32(32'h3F80_0000));
        step(1, 1, top32(32'h8000_0000));
        step(1, 1, {32'h0000_0001, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF});
        step(1, 1, top32(32'h007F_FFFF));
        step(1, 1, top32(32'h7F7F_FFFF));
        step(1, 1, top32(32'h7F80_0000));
        step(1, 1, top32(32'hFF80_0000));
        step(1, 1, top32(32'h7FC0_0001));
        step(1, 1, top32(32'h7F80_0001));
        // R1: idle cycles hold the payload
        step(0, 2, '1);
        step(0, 0, '0);
        // Double corners
        step(1, 2, top64(64'h3FF0_0000_0000_0000));
        step(1, 2, top64(64'h0000_0000_0000_0001));
        step(1, 2, top64(64'h7FF0_0000_0000_0000));
        step(1, 2, top64(64'h7FF0_0000_0000_0001));
        step(1, 2, top64(64'hFFF8_0000_0000_0000));
        step(1, 2, top64(64'h8000_0000_0000_0000));
        // Quad corners
        step(1, 3, {16'h3FFF, 112'd0});
        step(1, 3, 128'd1);
        step(1, 3, {16'h7FFF, 112'd0});
        step(1, 3, {16'h7FFF, 112'd1});
        step(1, 3, {16'hFFFF, 1'b1, 111'd0});
        step(1, 3, {16'h8000, 112'd0});
        step(1, 3, {16'h0000, 1'b1, 111'd0});
        // Random operands of every type, with occasional idle cycles
        for (int i = 0; i < 800; i++) begin
            logic [127:0] r;
            logic [1:0]   t;
            r = {$urandom, $urandom, $urandom, $urandom};
            t = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 5))
                0: r[126:112] = '0;
                1: r[126:112] = '1;
                2: if (t == 2'd1) r[126:119] = '1; else if (t == 2'd2) r[126:116] = '1;
                3: if (t == 2'd1) r[126:119] = '0; else if (t == 2'd2) r[126:116] = '0;
                default: ;
            endcase
            step(($urandom_range(0, 7) != 0), t, r);
        end
        step(0, 0, '0);
        step(0, 0, '0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule